// File: doc/BRIEF.md
# Up/Down Position Counter with Coherent Byte Readout

This block keeps a binary position count that steps up or down by one on each rising clock edge that carries an increment or decrement strobe. A holding register copies the count on every clock, so a host on a narrow 8-bit bus always reads a value at most one cycle old. The host fetches the upper byte and then the lower byte. Taking the upper byte freezes the holding register, so the lower byte that follows comes from the same sample even if the count moves meanwhile. The freeze ends by itself when the lower-byte access closes. The count keeps running the whole time, so no steps are lost.

A host that needs only eight bits keeps the byte select high. It then reads the low byte directly, and the freeze never starts. The count wraps in two's complement, so a host that samples often enough can recover motion from differences between samples.

Top module: `pos_read_latch`

## Requirements
- R1: An asynchronous active-low reset clears both the count and the holding register to zero at once; reads after reset return 0x00 for both bytes.
- R2: At a rising edge the count rises by one when only `step_up` is high and falls by one when only `step_dn` is high. When both strobes are high, or neither is, the count is unchanged.
- R3: The count wraps in two's complement: one increment from 0xFFFF gives 0x0000, and one decrement from 0x0000 gives 0xFFFF.
- R4: When not frozen, the holding register loads the count at every rising edge. A read therefore returns the count as it stood during the previous cycle.
- R5: `bus_q` shows the upper holding byte (bits 15:8) when `rd_stb` is 1 and `sel_lo` is 0. It shows the lower byte (bits 7:0) when `rd_stb` is 1 and `sel_lo` is 1. It is 0x00 whenever `rd_stb` is 0.
- R6: An upper-byte access (`rd_stb`=1, `sel_lo`=0) freezes the holding register from the edge that closes that access. A lower-byte access that follows returns the same sample, even if the count changed in between.
- R7: The freeze ends at the edge that closes a lower-byte access. The holding register loads again at the next edge, picking up every step counted while it was frozen.
- R8: A further upper-byte access while already frozen keeps the freeze and leaves the held sample unchanged.
- R9: With `sel_lo` held at 1 (8-bit use), no freeze ever starts, and each read returns the low byte of the count from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_up | input | 1 | Increment strobe |
| step_dn | input | 1 | Decrement strobe |
| rd_stb | input | 1 | Read strobe; high for one cycle per byte access |
| sel_lo | input | 1 | Byte select: 0 = upper byte, 1 = lower byte |
| bus_q | output | 8 | Read data; zero while `rd_stb` is low |

## Verification
The embedded properties assume that each byte access lasts exactly one clock with `rd_stb` high. They also assume that reset is released between clock edges. The stimulus raises every input just after a rising edge and holds it for one whole cycle, and it releases reset at the same offset. Upper and lower accesses may be separated by idle or counting cycles, and the strobes may overlap accesses. This lets the freeze be checked against a count that is still moving. Expected bytes come from a reference count that the driver keeps, plus the one-cycle holding delay stated in R4.

// File: rtl/pos_pkg.sv
package pos_pkg;

   // kind of bus access presented in one cycle
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_UPPER = 2'd1,
      ACC_LOWER = 2'd2
   } acc_kind_e;

   // decode of strobe pair into a count step
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_INC = 2'd1,
      STEP_DEC = 2'd2
   } step_e;

   function automatic acc_kind_e decode_access(input logic rd, input logic lo);
      if (!rd) return ACC_NONE;
      return lo ? ACC_LOWER : ACC_UPPER;
   endfunction

   function automatic step_e decode_step(input logic up, input logic dn);
      if (up && !dn) return STEP_INC;
      if (dn && !up) return STEP_DEC;
      return STEP_HOLD;
   endfunction

endpackage

// File: rtl/pos_updown_ctr.sv
module pos_updown_ctr
   import pos_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [WIDTH-1:0] count
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   step_e step;
   assign step = decode_step(inc, dec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         unique case (step)
            STEP_INC: count <= count + ONE;
            STEP_DEC: count <= count - ONE;
            default:  count <= count;
         endcase
      end
   end

   assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec) |=> count == WIDTH'($past(count) + ONE));
   assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |=> count == WIDTH'($past(count) - ONE));
   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc == dec) |=> $stable(count));
   assert_wrap_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && count == '1) |=> count == '0);

endmodule

// File: rtl/pos_read_ctl.sv
module pos_read_ctl
   import pos_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd,
   input  logic lo,
   output logic frozen,
   output logic load
);

   acc_kind_e acc;
   assign acc = decode_access(rd, lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frozen <= 1'b0;
      end else begin
         unique case (acc)
            ACC_UPPER: frozen <= 1'b1;
            ACC_LOWER: frozen <= 1'b0;
            default:   frozen <= frozen;
         endcase
      end
   end

   // no load at the edge closing an upper access, nor while frozen
   assign load = !frozen && (acc != ACC_UPPER);

   assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !lo) |=> frozen);
   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && lo) |=> !frozen);
   assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !(rd && lo)) |=> frozen);

endmodule

// File: rtl/pos_hold_reg.sv
module pos_hold_reg #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   assert_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(d));
   assert_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/pos_byte_mux.sv
module pos_byte_mux #(
   parameter int DATA_W = 16,
   parameter int BUS_W  = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic              rd,
   input  logic              lo,
   output logic [BUS_W-1:0]  q
);

   localparam int NLANE = DATA_W / BUS_W;

   logic [BUS_W-1:0] lane [NLANE];

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign lane[g] = data[g*BUS_W +: BUS_W];
   end

   assign q = !rd ? '0 : (lo ? lane[0] : lane[NLANE-1]);

endmodule

// File: rtl/pos_read_latch.sv
module pos_read_latch #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_up,
   input  logic             step_dn,
   input  logic             rd_stb,
   input  logic             sel_lo,
   output logic [BUS_W-1:0] bus_q
);

   localparam int NBYTE = CNT_W / BUS_W;

   if (BUS_W < 1) begin : g_bad_bus
      $error("BUS_W must be positive");
   end
   if (NBYTE != 2 || CNT_W % BUS_W != 0) begin : g_bad_ratio
      $error("CNT_W must be exactly two bus widths");
   end

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] held;
   logic             frozen;
   logic             load;

   pos_updown_ctr #(.WIDTH(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (step_up),
      .dec   (step_dn),
      .count (count)
   );

   pos_read_ctl u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd     (rd_stb),
      .lo     (sel_lo),
      .frozen (frozen),
      .load   (load)
   );

   pos_hold_reg #(.WIDTH(CNT_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .d     (count),
      .q     (held)
   );

   pos_byte_mux #(.DATA_W(CNT_W), .BUS_W(BUS_W)) u_mux (
      .data (held),
      .rd   (rd_stb),
      .lo   (sel_lo),
      .q    (bus_q)
   );

   assert_pair_coherent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !sel_lo) |=> (rd_stb && sel_lo) |-> $stable(held));
   assert_quiet_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |-> bus_q == '0);
   assert_byte_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && sel_lo && !frozen) |=> !frozen);

endmodule

// File: tb/tb_pos_read_latch.sv
module tb_pos_read_latch;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_up = 1'b0;
   logic       step_dn = 1'b0;
   logic       rd_stb = 1'b0;
   logic       sel_lo = 1'b0;
   logic [7:0] bus_q;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [15:0] ref_cnt = 16'h0000;
   logic [7:0]  q_val [$];
   string       q_tag [$];

   always #4 clk = ~clk;

   pos_read_latch dut (
      .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
      .rd_stb(rd_stb), .sel_lo(sel_lo), .bus_q(bus_q)
   );

   // monitor: compare each read byte against the scoreboard queue
   always @(negedge clk) begin : mon
      logic [7:0] e;
      string t;
      if (rst_n && rd_stb) begin
         n_run++;
         if (q_val.size() == 0) begin
            n_fail++;
            $display("FAIL R5: unexpected read, actual %02h expected none", bus_q);
         end else begin
            e = q_val.pop_front();
            t = q_tag.pop_front();
            if (bus_q !== e) begin
               n_fail++;
               $display("FAIL %s: actual %02h expected %02h", t, bus_q, e);
            end
         end
      end
   end

   task automatic drive(input logic up, input logic dn, input logic rd, input logic lo);
      @(posedge clk);
      #1;
      step_up = up; step_dn = dn; rd_stb = rd; sel_lo = lo;
   endtask

   task automatic expect_b(input logic [7:0] v, input string tag);
      q_val.push_back(v);
      q_tag.push_back(tag);
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic count(input int n, input bit up);
      for (int i = 0; i < n; i++) begin
         drive(up, !up, 1'b0, 1'b0);
         ref_cnt = up ? ref_cnt + 16'd1 : ref_cnt - 16'd1;
      end
      idle();
   endtask

   // precondition: holding register equals ref_cnt
   task automatic read_pair(input string tag);
      logic [15:0] snap;
      snap = ref_cnt;
      drive(1'b0, 1'b0, 1'b1, 1'b0); expect_b(snap[15:8], tag);
      drive(1'b0, 1'b0, 1'b1, 1'b1); expect_b(snap[7:0], tag);
      idle();
      idle();
   endtask

   task automatic quiet_check(input string tag);
      drive(1'b1, 1'b1, 1'b0, 1'b1);
      @(negedge clk);
      n_run++;
      if (bus_q !== 8'h00) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected 00", tag, bus_q);
      end
   endtask

   task automatic do_reset();
      @(posedge clk);
      #2 rst_n = 1'b0;
      step_up = 1'b0; step_dn = 1'b0; rd_stb = 1'b0; sel_lo = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      ref_cnt = 16'h0000;
      idle();
   endtask

   initial begin : wdog
      #(8 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] snap;
      logic [15:0] base;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle();
      // R1: state after power-up reset
      read_pair("R1");
      // R5: bus quiet without strobe; both strobes also leave count alone
      quiet_check("R5");
      read_pair("R2");
      // R2: up, down, and simultaneous strobes
      count(300, 1'b1);
      read_pair("R2");
      count(45, 1'b0);
      read_pair("R2");
      repeat (3) drive(1'b1, 1'b1, 1'b0, 1'b0);
      idle();
      read_pair("R2");
      // R4: read right after a step sees the prior-cycle value
      drive(1'b1, 1'b0, 1'b0, 1'b0);
      ref_cnt = ref_cnt + 16'd1;
      drive(1'b0, 1'b0, 1'b1, 1'b1); expect_b(8'(ref_cnt - 16'd1), "R4");
      drive(1'b0, 1'b0, 1'b1, 1'b1); expect_b(ref_cnt[7:0], "R4");
      idle();
      // bring low byte to FF so counting while frozen carries upward
      count(int'(8'hFF - ref_cnt[7:0]), 1'b1);
      // R6 / R7: pair read while counting, then catch-up
      snap = ref_cnt;
      drive(1'b1, 1'b0, 1'b1, 1'b0); expect_b(snap[15:8], "R6");
      drive(1'b1, 1'b0, 1'b1, 1'b1); expect_b(snap[7:0], "R6");
      ref_cnt = ref_cnt + 16'd2;
      drive(1'b0, 1'b0, 1'b1, 1'b1); expect_b(snap[7:0], "R7");
      drive(1'b0, 1'b0, 1'b1, 1'b1); expect_b(ref_cnt[7:0], "R7");
      idle();
      read_pair("R7");
      // R8: repeated upper access while frozen
      snap = ref_cnt;
      drive(1'b0, 1'b0, 1'b1, 1'b0); expect_b(snap[15:8], "R8");
      drive(1'b1, 1'b0, 1'b0, 1'b0);
      drive(1'b1, 1'b0, 1'b1, 1'b0); expect_b(snap[15:8], "R8");
      drive(1'b0, 1'b0, 1'b1, 1'b1); expect_b(snap[7:0], "R8");
      ref_cnt = ref_cnt + 16'd2;
      idle();
      idle();
      read_pair("R8");
      // R1: reset in mid-run
      count(5, 1'b1);
      do_reset();
      read_pair("R1");
      // R3: wrap both ways
      count(1, 1'b0);
      read_pair("R3");
      count(1, 1'b1);
      read_pair("R3");
      // R9: select held high, read every cycle while counting
      count(250, 1'b1);
      drive(1'b0, 1'b0, 1'b0, 1'b1);
      base = ref_cnt;
      for (int i = 0; i < 8; i++) begin
         drive(1'b1, 1'b0, 1'b1, 1'b1);
         expect_b(8'(base + 16'((i >= 1) ? i - 1 : 0)), "R9");
      end
      ref_cnt = ref_cnt + 16'd8;
      drive(1'b0, 1'b0, 1'b0, 1'b1);
      drive(1'b0, 1'b0, 1'b1, 1'b1); expect_b(ref_cnt[7:0], "R9");
      idle();
      read_pair("R9");
      idle();
      idle();
      if (q_val.size() != 0) begin
         n_run++;
         n_fail++;
         $display("FAIL R5: actual %0d reads missing expected 0", q_val.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule